// File: doc/BRIEF.md
# Deadline-Aware Read-Priority Memory Scheduler

This block sits between request sources and a memory whose writes take much longer than its reads. Each request carries a tag, an address, a write flag, write data and an absolute deadline stated against the block's free-running cycle counter, which the block exposes so that sources can form deadlines. Reads enter a read queue and writes enter a separate write buffer. Whenever at least one read is waiting, the scheduler issues the most urgent read. It drains the most urgent buffered write only when the read queue is empty.

Urgency is the slack: the deadline minus the current counter value, compared as a signed number, so a smaller value is more urgent. The block issues one command at a time and keeps the memory busy for a fixed service time. A read takes `RD_CYCLES` cycles and a write takes three times as long. When the service ends, the block reports a completion with the tag, the read data and a flag that says whether the deadline was missed.

The control is a three-state machine. `ST_IDLE` waits for work. It takes the transition *issue-read* to `ST_RD_SVC` when any read is queued. It takes *issue-write* to `ST_WR_SVC` when no read is queued but a write is buffered. Both service states count their service time down and take *complete* back to `ST_IDLE` when the count reaches zero. Neither service state leaves early: an issued command is never pre-empted.

Top module: `mem_sched`

## Requirements
- R1: A request with `req_write`=1 goes to the write buffer and one with `req_write`=0 goes to the read queue. Each holds `DEPTH` (8) entries and fills its lowest free slot. `req_ready` is low while the addressed queue is full, and a held request is accepted once room appears.
- R2: A write is issued only in a cycle where the read queue holds no entry at the issue decision, so reads always win.
- R3: Among queued reads, the one issued has the smallest signed slack `req_deadline - cycle_now`. On a tie, the lower slot index wins.
- R4: Among buffered writes, the same slack rule and the same tie rule select the write to issue.
- R5: `mem_cmd_valid` pulses for one cycle as `mem_busy` rises. `mem_busy` then stays high for exactly `RD_CYCLES` cycles for a read and `3*RD_CYCLES` cycles for a write.
- R6: No command starts while `mem_busy` is high. A request that arrives during a service waits for that service to finish.
- R7: `done` is high for one cycle, in the first cycle after `mem_busy` falls. It presents the tag, the write flag and, for a read, the `mem_rdata` value held on the last busy cycle. For a write, `done_rdata` is 0.
- R8: `done_missed` is 1 exactly when `cycle_now` during the `done` cycle is later than the request's deadline (signed difference).
- R9: After reset, both queues are empty, `req_ready` is high, `mem_busy`, `mem_cmd_valid` and `done` are low, and `cycle_now` restarts from 0, adding one per clock.
- R10: A full write buffer stalls only incoming writes. Reads are still accepted and are still issued ahead of every buffered write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Addressed queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Request tag |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_deadline | input | TIME_W | Absolute deadline against `cycle_now` |
| cycle_now | output | TIME_W | Free-running cycle counter |
| mem_cmd_valid | output | 1 | One-cycle command start |
| mem_cmd_write | output | 1 | Command is a write |
| mem_cmd_addr | output | ADDR_W | Command address, held during service |
| mem_cmd_wdata | output | DATA_W | Command write data, held during service |
| mem_busy | output | 1 | Memory occupied by the current command |
| mem_rdata | input | DATA_W | Read data from memory |
| done | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |
| done_write | output | 1 | Completed request was a write |
| done_rdata | output | DATA_W | Read data (0 for writes) |
| done_missed | output | 1 | Completion came after the deadline |

## Verification
The bench fills the read queue behind a long write, with tied deadlines. A picker that mishandled ties would issue slots out of index order, and a design that pre-empted would start a read while `mem_busy` is still high. It then fills the write buffer while a write is in service and offers further reads. A design that promoted writes when the buffer is full would issue a write while reads are queued. The same scenario shows whether a full write buffer wrongly blocks reads or wrongly accepts a ninth write. A long mixed sweep mixes deadlines that are already past with deadlines well in the future, and keeps pushing into slots that were just freed. An off-by-one in the service counter shows up as a wrong busy length. A wrong completion comparison shows up as a wrong missed flag, and a wrong free-slot choice shows up as a wrong tie order.

// File: rtl/msch_pkg.sv
package msch_pkg;

    parameter int TAG_W  = 4;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 16;
    parameter int TIME_W = 16;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [TIME_W-1:0] deadline;
    } msch_req_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_SVC = 2'd1,
        ST_WR_SVC = 2'd2
    } msch_state_t;

endpackage

// File: rtl/msch_queue.sv
module msch_queue
    import msch_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  msch_req_t        push_req,
    input  logic             pop,
    input  logic [IDX_W-1:0] pop_idx,
    output msch_req_t        slots [DEPTH],
    output logic [DEPTH-1:0] valid,
    output logic             full
);

    logic [IDX_W-1:0] free_idx;

    // lowest free slot
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign full = &valid;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[gi] <= 1'b0;
                slots[gi] <= '0;
            end else if (push && (free_idx == IDX_W'(gi))) begin
                valid[gi] <= 1'b1;
                slots[gi] <= push_req;
            end else if (pop && (pop_idx == IDX_W'(gi))) begin
                valid[gi] <= 1'b0;
            end
        end
    end

    // R1: a push never arrives at a full queue
    p_push_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R1: occupancy grows by one on a lone push
    p_count_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> ($countones(valid) == $past($countones(valid)) + 1));

    // R3: the popped slot holds a live entry
    p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> valid[pop_idx]);

endmodule

// File: rtl/msch_pick.sv
module msch_pick
    import msch_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  msch_req_t        slots [DEPTH],
    input  logic [DEPTH-1:0] valid,
    input  logic [TIME_W-1:0] now,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [TIME_W-1:0] slack [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slack
        assign slack[gi] = slots[gi].deadline - now;
    end

    // strict less-than keeps the lower index on a tie
    always_comb begin
        logic [TIME_W-1:0] best;
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid[i] && (!any || ($signed(slack[i]) < $signed(best)))) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = slack[i];
            end
        end
    end

endmodule

// File: rtl/mem_sched.sv
module mem_sched
    import msch_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int RD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TIME_W-1:0] req_deadline,
    output logic [TIME_W-1:0] cycle_now,
    output logic              mem_cmd_valid,
    output logic              mem_cmd_write,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [DATA_W-1:0] mem_cmd_wdata,
    output logic              mem_busy,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [TAG_W-1:0]  done_tag,
    output logic              done_write,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_missed
);

    localparam int WR_CYCLES = 3 * RD_CYCLES;
    localparam int CNT_W     = $clog2(WR_CYCLES + 1);
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    msch_state_t state, state_nx;

    msch_req_t        in_req;
    msch_req_t        rd_slots [DEPTH];
    msch_req_t        wr_slots [DEPTH];
    logic [DEPTH-1:0] rd_valid, wr_valid;
    logic             rd_full, wr_full;
    logic             rd_any, wr_any;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             push_rd, push_wr;
    logic             issue_rd, issue_wr;
    logic             svc_last;
    logic [CNT_W-1:0] svc_cnt;
    logic [TAG_W-1:0]  cur_tag;
    logic [TIME_W-1:0] cur_deadline;
    logic [TIME_W-1:0] late_diff;

    // request routing
    assign in_req    = '{tag: req_tag, addr: req_addr, wdata: req_wdata, deadline: req_deadline};
    assign req_ready = req_write ? !wr_full : !rd_full;
    assign push_rd   = req_valid && !req_write && !rd_full;
    assign push_wr   = req_valid &&  req_write && !wr_full;

    msch_queue #(.DEPTH(DEPTH)) u_rd_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_rd),
        .push_req (in_req),
        .pop      (issue_rd),
        .pop_idx  (rd_idx),
        .slots    (rd_slots),
        .valid    (rd_valid),
        .full     (rd_full)
    );

    msch_queue #(.DEPTH(DEPTH)) u_wr_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_wr),
        .push_req (in_req),
        .pop      (issue_wr),
        .pop_idx  (wr_idx),
        .slots    (wr_slots),
        .valid    (wr_valid),
        .full     (wr_full)
    );

    msch_pick #(.DEPTH(DEPTH)) u_rd_pick (
        .slots (rd_slots),
        .valid (rd_valid),
        .now   (cycle_now),
        .any   (rd_any),
        .idx   (rd_idx)
    );

    msch_pick #(.DEPTH(DEPTH)) u_wr_pick (
        .slots (wr_slots),
        .valid (wr_valid),
        .now   (cycle_now),
        .any   (wr_any),
        .idx   (wr_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: issue-read, issue-write, complete
    always_comb begin
        issue_rd = 1'b0;
        issue_wr = 1'b0;
        svc_last = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_any) begin
                    issue_rd = 1'b1;
                    state_nx = ST_RD_SVC;
                end else if (wr_any) begin
                    issue_wr = 1'b1;
                    state_nx = ST_WR_SVC;
                end
            end
            ST_RD_SVC, ST_WR_SVC: begin
                if (svc_cnt == '0) begin
                    svc_last = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign mem_busy  = (state != ST_IDLE);
    assign late_diff = (cycle_now + TIME_W'(1)) - cur_deadline;

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_now     <= '0;
            mem_cmd_valid <= 1'b0;
            mem_cmd_write <= 1'b0;
            mem_cmd_addr  <= '0;
            mem_cmd_wdata <= '0;
            svc_cnt       <= '0;
            cur_tag       <= '0;
            cur_deadline  <= '0;
            done          <= 1'b0;
            done_tag      <= '0;
            done_write    <= 1'b0;
            done_rdata    <= '0;
            done_missed   <= 1'b0;
        end else begin
            cycle_now     <= cycle_now + TIME_W'(1);
            mem_cmd_valid <= issue_rd || issue_wr;
            done          <= svc_last;
            if (issue_rd) begin
                mem_cmd_write <= 1'b0;
                mem_cmd_addr  <= rd_slots[rd_idx].addr;
                mem_cmd_wdata <= rd_slots[rd_idx].wdata;
                cur_tag       <= rd_slots[rd_idx].tag;
                cur_deadline  <= rd_slots[rd_idx].deadline;
                svc_cnt       <= CNT_W'(RD_CYCLES - 1);
            end else if (issue_wr) begin
                mem_cmd_write <= 1'b1;
                mem_cmd_addr  <= wr_slots[wr_idx].addr;
                mem_cmd_wdata <= wr_slots[wr_idx].wdata;
                cur_tag       <= wr_slots[wr_idx].tag;
                cur_deadline  <= wr_slots[wr_idx].deadline;
                svc_cnt       <= CNT_W'(WR_CYCLES - 1);
            end else if (mem_busy && (svc_cnt != '0)) begin
                svc_cnt <= svc_cnt - CNT_W'(1);
            end
            if (svc_last) begin
                done_tag    <= cur_tag;
                done_write  <= mem_cmd_write;
                done_rdata  <= mem_cmd_write ? '0 : mem_rdata;
                done_missed <= !late_diff[TIME_W-1] && (late_diff != '0);
            end
        end
    end

    // checker counter for the busy window length
    logic [CNT_W:0] chk_busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_busy_len <= '0;
        end else if (mem_busy) begin
            chk_busy_len <= chk_busy_len + 1'b1;
        end else begin
            chk_busy_len <= '0;
        end
    end

    // R2: a write starts only when no read was waiting
    p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && mem_cmd_write) |-> $past(rd_valid == '0));

    // R5: command start is a single-cycle pulse
    p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |=> !mem_cmd_valid);

    // R5: busy window length matches the command kind
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_busy_len == (done_write ? (CNT_W+1)'(WR_CYCLES) : (CNT_W+1)'(RD_CYCLES))));

    // R6: no start while the memory is occupied
    p_no_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> !$past(mem_busy));

    // R7: completion follows the end of a service
    p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_busy && $past(mem_busy)));

endmodule

// File: tb/test_mem_sched.sv
module test_mem_sched;
    import msch_pkg::*;

    localparam int DEPTH = 8;
    localparam int RDC   = 4;
    localparam int WRC   = 3 * RDC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [TIME_W-1:0] req_deadline = '0;
    logic [TIME_W-1:0] cycle_now;
    logic              mem_cmd_valid, mem_cmd_write, mem_busy;
    logic [ADDR_W-1:0] mem_cmd_addr;
    logic [DATA_W-1:0] mem_cmd_wdata, mem_rdata;
    logic              done, done_write, done_missed;
    logic [TAG_W-1:0]  done_tag;
    logic [DATA_W-1:0] done_rdata;

    always #5 clk = ~clk;

    function automatic logic [DATA_W-1:0] rd_fn(logic [ADDR_W-1:0] a);
        return DATA_W'(a) * DATA_W'(5) + DATA_W'(3);
    endfunction

    assign mem_rdata = rd_fn(mem_cmd_addr);

    mem_sched #(.DEPTH(DEPTH), .RD_CYCLES(RDC)) i_mem_sched (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_tag(req_tag), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_deadline(req_deadline), .cycle_now(cycle_now),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
        .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
        .mem_busy(mem_busy), .mem_rdata(mem_rdata),
        .done(done), .done_tag(done_tag), .done_write(done_write),
        .done_rdata(done_rdata), .done_missed(done_missed)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_miss   = 0;
    int n_met    = 0;
    int push_cnt = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model of both queues, slot-exact
    logic      mv [2][DEPTH];
    msch_req_t ms [2][DEPTH];

    // push staged for the coming edge
    logic      stg_v = 1'b0;
    logic      stg_w = 1'b0;
    msch_req_t stg_r;

    // expectation for the command in flight
    msch_req_t exp_r;
    logic      exp_w = 1'b0;
    logic      mon_en = 1'b0;
    logic      prev_busy = 1'b0;
    int        busy_len = 0;

    function automatic int free_slot(int q);
        for (int i = 0; i < DEPTH; i++) if (!mv[q][i]) return i;
        return -1;
    endfunction

    function automatic bit model_empty(int q);
        for (int i = 0; i < DEPTH; i++) if (mv[q][i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int model_pick(int q, logic [TIME_W-1:0] ref_now);
        int best = -1;
        logic [TIME_W-1:0] sb, si;
        sb = '0;
        for (int i = 0; i < DEPTH; i++) begin
            si = ms[q][i].deadline - ref_now;
            if (mv[q][i] && (best < 0 || $signed(si) < $signed(sb))) begin
                best = i;
                sb = si;
            end
        end
        return best;
    endfunction

    // monitor, sampling 2 ns after each rising edge
    always @(posedge clk) begin
        int fs, q, pi;
        logic [TIME_W-1:0] late;
        #2;
        if (mon_en) begin
            fs = stg_v ? free_slot(int'(stg_w)) : -1;
            if (mem_cmd_valid) begin
                chk("R6 start while idle", {31'd0, prev_busy}, 32'd0);
                q = model_empty(0) ? 1 : 0;
                chk("R2 read before write", {31'd0, mem_cmd_write}, q);
                pi = model_pick(q, cycle_now - TIME_W'(1));
                if (pi < 0) begin
                    chk("R2 command with empty model", 32'd1, 32'd0);
                end else begin
                    chk(q ? "R4 write pick addr" : "R3 read pick addr",
                        32'(mem_cmd_addr), 32'(ms[q][pi].addr));
                    if (q == 1) chk("R4 write data", 32'(mem_cmd_wdata), 32'(ms[q][pi].wdata));
                    exp_r = ms[q][pi];
                    exp_w = q[0];
                    mv[q][pi] = 1'b0;
                end
            end
            if (stg_v) begin
                if (fs < 0) chk("R1 push into full model", 32'd1, 32'd0);
                else begin
                    mv[int'(stg_w)][fs] = 1'b1;
                    ms[int'(stg_w)][fs] = stg_r;
                end
                stg_v = 1'b0;
            end
            if (done) begin
                chk("R5 busy length", 32'(busy_len), exp_w ? WRC : RDC);
                chk("R7 done tag", 32'(done_tag), 32'(exp_r.tag));
                chk("R7 done write flag", {31'd0, done_write}, {31'd0, exp_w});
                chk("R7 done rdata", 32'(done_rdata), exp_w ? 32'd0 : 32'(rd_fn(exp_r.addr)));
                late = cycle_now - exp_r.deadline;
                chk("R8 missed flag", {31'd0, done_missed},
                    {31'd0, ($signed(late) > 0)});
                if ($signed(late) > 0) n_miss++; else n_met++;
                busy_len = 0;
            end
            if (mem_busy) busy_len++;
            prev_busy = mem_busy;
        end
    end

    task automatic push(input bit w, input logic [TIME_W-1:0] dl);
        @(negedge clk);
        req_valid    = 1'b1;
        req_write    = w;
        req_tag      = TAG_W'(push_cnt);
        req_addr     = ADDR_W'(push_cnt);
        req_wdata    = DATA_W'(push_cnt * 37 + 1);
        req_deadline = dl;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        stg_r = '{tag: req_tag, addr: req_addr, wdata: req_wdata, deadline: req_deadline};
        stg_w = w;
        stg_v = 1'b1;
        push_cnt++;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic probe_ready(input bit w, input bit exp, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        #1;
        chk(req, {31'd0, req_ready}, {31'd0, exp});
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        idle_cycle();
        while (guard < 2000 && !(model_empty(0) && model_empty(1) && !mem_busy
                                 && !stg_v && !mem_cmd_valid)) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [TIME_W-1:0] base;
        int offs [8] = '{50, 20, 20, 90, 5, 20, 70, 5};
        for (int q = 0; q < 2; q++)
            for (int i = 0; i < DEPTH; i++) begin
                mv[q][i] = 1'b0;
                ms[q][i] = '0;
            end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R9 busy after reset", {31'd0, mem_busy}, 32'd0);
        chk("R9 done after reset", {31'd0, done}, 32'd0);
        chk("R9 cmd after reset", {31'd0, mem_cmd_valid}, 32'd0);
        chk("R9 counter in reset", 32'(cycle_now), 32'd0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk("R9 counter after one edge", 32'(cycle_now), 32'd1);
        @(negedge clk);
        chk("R9 counter after two edges", 32'(cycle_now), 32'd2);

        // R1 R3 R6: reads pile up behind a long write, with ties
        base = cycle_now;
        push(1'b1, base + TIME_W'(400));
        for (int k = 0; k < 8; k++) push(1'b0, base + TIME_W'(offs[k]));
        probe_ready(1'b0, 1'b0, "R1 read queue full holds ready low");
        probe_ready(1'b1, 1'b1, "R1 write buffer has room");
        drain();

        // R10 R4: write buffer full while a write is served
        base = cycle_now;
        push(1'b1, base + TIME_W'(500));
        for (int k = 0; k < 8; k++) push(1'b1, base + TIME_W'(offs[7 - k] + 30));
        probe_ready(1'b1, 1'b0, "R10 full write buffer stalls writes");
        probe_ready(1'b0, 1'b1, "R10 reads accepted with full write buffer");
        push(1'b0, base + TIME_W'(900));
        push(1'b0, base + TIME_W'(800));
        push(1'b1, base + TIME_W'(10));
        drain();

        // R1..R8: mixed sweep with past and future deadlines
        for (int k = 0; k < 1500; k++) begin
            if ($urandom_range(0, 3) == 0) idle_cycle();
            else push($urandom_range(0, 2) == 0,
                      cycle_now + TIME_W'($urandom_range(0, 80)) - TIME_W'(20));
        end
        drain();

        chk("R8 some completions late", {31'd0, (n_miss > 0)}, 32'd1);
        chk("R8 some completions on time", {31'd0, (n_met > 0)}, 32'd1);
        finish_run();
    end

endmodule